// File: doc/BRIEF.md
# Accumulator ALU with Shifter

This block is the arithmetic heart of a small accumulator machine. It is purely combinational. For every instruction it takes the opcode, the current 16-bit accumulator, the 16-bit word last read from memory and the 8-bit operand field of the instruction. From these it produces the value the accumulator should take next.

Beside that value it reports whether the opcode writes the accumulator at all. It also gives two condition flags, zero and negative, that the sequencer uses to decide the conditional jumps.

Most operations take their second operand from the memory word. Immediate add and the two shifts take it from the instruction field instead. A shift uses only the low nibble of that field as its amount. The block holds no state and has no handshake. When its inputs change, its outputs settle within the same clock period.

Top module: `acc_alu`

## Requirements
- R1: Opcode 0x00 gives accumulator plus memory word, and opcode 0x05 gives accumulator minus memory word. Both wrap modulo 2^16.
- R2: Opcodes 0x06, 0x07 and 0x08 give the bitwise XOR, OR and AND of accumulator and memory word, computed independently for each of the 16 bits.
- R3: Opcode 0x0B adds the 8-bit operand field, zero-extended to 16 bits, to the accumulator, wrapping modulo 2^16.
- R4: Opcode 0x0D shifts the accumulator left by operand field bits [3:0] (0 to 15 places) and fills the vacated bits with zeros.
- R5: Opcode 0x0E shifts the accumulator right by operand field bits [3:0] (0 to 15 places) and fills the vacated bits with zeros.
- R6: For both shifts, operand field bits [7:4] have no effect on the result.
- R7: Opcode 0x02 passes the memory word through unchanged as the next accumulator value.
- R8: The write-enable output is 1 exactly for opcodes 0x00, 0x02, 0x05, 0x06, 0x07, 0x08, 0x0B, 0x0D and 0x0E, and 0 for every other code from 0x00 to 0xFF.
- R9: For any opcode whose write-enable is 0, the next-value output equals the current accumulator.
- R10: The zero flag is 1 exactly when the current accumulator is 0x0000.
- R11: The negative flag equals bit 15 of the current accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 8 | Instruction opcode |
| acc_i | input | 16 | Current accumulator value |
| mdr_i | input | 16 | Word read from memory |
| field_i | input | 8 | Instruction operand field (immediate or shift amount) |
| acc_next_o | output | 16 | Next accumulator value |
| acc_we_o | output | 1 | High when the opcode writes the accumulator |
| zero_o | output | 1 | Current accumulator equals zero |
| neg_o | output | 1 | Current accumulator is negative (bit 15) |

## Verification
Every output is a pure function of the present inputs, so each result is due in the same clock period in which its stimulus is applied. There are no registers, so it is never due on a later edge. The bench drives a new input set just after a rising edge of its own clock. It samples the outputs at the following falling edge, half a period later, when no input is moving. The corner values are chosen to tell the operations apart from their nearby variants: wrap-around, zero-extension against sign-extension, logical against arithmetic right shift, and a shift field with nonzero upper bits.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OPC_W = 8;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD   = 8'h00,
    OPC_STORE = 8'h01,
    OPC_LOAD  = 8'h02,
    OPC_JUMP  = 8'h03,
    OPC_JNEG  = 8'h04,
    OPC_SUB   = 8'h05,
    OPC_XOR   = 8'h06,
    OPC_OR    = 8'h07,
    OPC_AND   = 8'h08,
    OPC_JPOS  = 8'h09,
    OPC_JZERO = 8'h0A,
    OPC_ADDI  = 8'h0B,
    OPC_OUT   = 8'h0C,
    OPC_SHL   = 8'h0D,
    OPC_SHR   = 8'h0E
  } opc_e;

  typedef enum logic [1:0] {
    LOGIC_XOR = 2'd0,
    LOGIC_OR  = 2'd1,
    LOGIC_AND = 2'd2
  } logic_op_e;
endpackage

// File: rtl/acc_operand_sel.sv
module acc_operand_sel #(
  parameter int DATA_W  = 16,
  parameter int FIELD_W = 8,
  parameter int SHAMT_W = 4
) (
  input  logic [FIELD_W-1:0] field_i,
  output logic [DATA_W-1:0]  imm_o,
  output logic [SHAMT_W-1:0] shamt_o
);
  localparam int PAD_W = DATA_W - FIELD_W;

  // zero-extended immediate
  assign imm_o   = {{PAD_W{1'b0}}, field_i};
  // only the low bits of the field carry the shift amount
  assign shamt_o = field_i[SHAMT_W-1:0];
endmodule

// File: rtl/acc_logic_unit.sv
module acc_logic_unit
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic_op_e         op_i,
  output logic [DATA_W-1:0] y_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    always_comb begin
      unique case (op_i)
        LOGIC_XOR: y_o[b] = a_i[b] ^ b_i[b];
        LOGIC_OR:  y_o[b] = a_i[b] | b_i[b];
        default:   y_o[b] = a_i[b] & b_i[b];
      endcase
    end
  end
endmodule

// File: rtl/acc_shifter.sv
module acc_shifter #(
  parameter int DATA_W  = 16,
  parameter int SHAMT_W = 4,
  parameter bit LEFT    = 1'b1
) (
  input  logic [DATA_W-1:0]  a_i,
  input  logic [SHAMT_W-1:0] amt_i,
  output logic [DATA_W-1:0]  y_o
);
  logic [DATA_W-1:0] stage [0:SHAMT_W];

  assign stage[0] = a_i;

  for (genvar i = 0; i < SHAMT_W; i++) begin : g_stage
    if (LEFT) begin : g_left
      assign stage[i+1] = amt_i[i] ? (stage[i] << (2**i)) : stage[i];
    end else begin : g_right
      assign stage[i+1] = amt_i[i] ? (stage[i] >> (2**i)) : stage[i];
    end
  end

  assign y_o = stage[SHAMT_W];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int FIELD_W = 8,
  parameter int SHAMT_W = 4
) (
  input  logic [OPC_W-1:0]   opcode_i,
  input  logic [DATA_W-1:0]  acc_i,
  input  logic [DATA_W-1:0]  mdr_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic [DATA_W-1:0]  acc_next_o,
  output logic               acc_we_o,
  output logic               zero_o,
  output logic               neg_o
);
  logic [DATA_W-1:0]  imm;
  logic [SHAMT_W-1:0] shamt;
  logic [DATA_W-1:0]  sum_mem, sum_imm, diff_mem;
  logic [DATA_W-1:0]  logic_y, shl_y, shr_y;
  logic_op_e          lop;

  acc_operand_sel #(.DATA_W(DATA_W), .FIELD_W(FIELD_W), .SHAMT_W(SHAMT_W)) u_opsel (
    .field_i (field_i),
    .imm_o   (imm),
    .shamt_o (shamt)
  );

  assign sum_mem  = acc_i + mdr_i;
  assign sum_imm  = acc_i + imm;
  assign diff_mem = acc_i - mdr_i;

  always_comb begin
    unique case (opcode_i)
      OPC_XOR: lop = LOGIC_XOR;
      OPC_OR:  lop = LOGIC_OR;
      default: lop = LOGIC_AND;
    endcase
  end

  acc_logic_unit #(.DATA_W(DATA_W)) u_logic (
    .a_i  (acc_i),
    .b_i  (mdr_i),
    .op_i (lop),
    .y_o  (logic_y)
  );

  acc_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .LEFT(1'b1)) u_shl (
    .a_i   (acc_i),
    .amt_i (shamt),
    .y_o   (shl_y)
  );

  acc_shifter #(.DATA_W(DATA_W), .SHAMT_W(SHAMT_W), .LEFT(1'b0)) u_shr (
    .a_i   (acc_i),
    .amt_i (shamt),
    .y_o   (shr_y)
  );

  always_comb begin
    acc_next_o = acc_i;
    acc_we_o   = 1'b1;
    case (opcode_i)
      OPC_ADD:                  acc_next_o = sum_mem;
      OPC_SUB:                  acc_next_o = diff_mem;
      OPC_LOAD:                 acc_next_o = mdr_i;
      OPC_XOR, OPC_OR, OPC_AND: acc_next_o = logic_y;
      OPC_ADDI:                 acc_next_o = sum_imm;
      OPC_SHL:                  acc_next_o = shl_y;
      OPC_SHR:                  acc_next_o = shr_y;
      default:                  acc_we_o   = 1'b0;
    endcase
  end

  assign zero_o = (acc_i == '0);
  assign neg_o  = acc_i[DATA_W-1];
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int FIELD_W = 8,
  parameter int SHAMT_W = 4
) (
  input logic [OPC_W-1:0]   opcode_i,
  input logic [DATA_W-1:0]  acc_i,
  input logic [DATA_W-1:0]  mdr_i,
  input logic [FIELD_W-1:0] field_i,
  input logic [DATA_W-1:0]  acc_next_o,
  input logic               acc_we_o,
  input logic               zero_o,
  input logic               neg_o
);
  logic [DATA_W-1:0] low_mask;
  assign low_mask = (DATA_W'(1) << field_i[SHAMT_W-1:0]) - DATA_W'(1);

  always_comb begin
    // R9
    hold_when_idle_chk: assert (acc_we_o || acc_next_o == acc_i);
    // R4
    shl_zero_fill_chk: assert (opcode_i != OPC_SHL || (acc_next_o & low_mask) == '0);
    // R6
    shift_zero_amt_chk: assert (!((opcode_i == OPC_SHL || opcode_i == OPC_SHR) &&
                                  field_i[SHAMT_W-1:0] == '0) || acc_next_o == acc_i);
    // R2
    or_subset_chk: assert (opcode_i != OPC_OR || (acc_next_o & ~(acc_i | mdr_i)) == '0);
    // R2
    and_subset_chk: assert (opcode_i != OPC_AND || (acc_next_o & ~(acc_i & mdr_i)) == '0);
    // R10
    flags_excl_chk: assert (!(zero_o && neg_o));
  end
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W), .FIELD_W(FIELD_W), .SHAMT_W(SHAMT_W)) u_chk (
  .opcode_i   (opcode_i),
  .acc_i      (acc_i),
  .mdr_i      (mdr_i),
  .field_i    (field_i),
  .acc_next_o (acc_next_o),
  .acc_we_o   (acc_we_o),
  .zero_o     (zero_o),
  .neg_o      (neg_o)
);

// File: tb/acc_alu_test.sv
module acc_alu_test;
  logic        clk = 1'b0;
  logic [7:0]  opcode;
  logic [15:0] acc, mdr;
  logic [7:0]  field;
  logic [15:0] acc_next;
  logic        acc_we, zero, neg;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  acc_alu uut (
    .opcode_i   (opcode),
    .acc_i      (acc),
    .mdr_i      (mdr),
    .field_i    (field),
    .acc_next_o (acc_next),
    .acc_we_o   (acc_we),
    .zero_o     (zero),
    .neg_o      (neg)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] op, input logic [15:0] a, input logic [15:0] m,
                       input logic [7:0] f);
    @(posedge clk);
    #1;
    opcode = op; acc = a; mdr = m; field = f;
    @(negedge clk);
  endtask

  task automatic test_idle_state();
    apply(8'h00, 16'h0000, 16'h0000, 8'h00);
    check("R1 zero inputs", acc_next, 16'h0000);
    check("R10 zero inputs", {15'd0, zero}, 16'd1);
  endtask

  task automatic test_add_sub();
    apply(8'h00, 16'h7FFF, 16'h0001, 8'h00);
    check("R1 add", acc_next, 16'h8000);
    apply(8'h00, 16'hFFFF, 16'h0002, 8'h00);
    check("R1 add wrap", acc_next, 16'h0001);
    apply(8'h05, 16'h0003, 16'h0005, 8'h00);
    check("R1 sub wrap", acc_next, 16'hFFFE);
    apply(8'h05, 16'h1000, 16'h0001, 8'h00);
    check("R1 sub", acc_next, 16'h0FFF);
  endtask

  task automatic test_bitwise();
    apply(8'h06, 16'hA5A5, 16'h0FF0, 8'h00);
    check("R2 xor", acc_next, 16'hAA55);
    apply(8'h07, 16'hA5A5, 16'h0FF0, 8'h00);
    check("R2 or", acc_next, 16'hAFF5);
    apply(8'h08, 16'hA5A5, 16'h0FF0, 8'h00);
    check("R2 and", acc_next, 16'h05A0);
  endtask

  task automatic test_addi();
    apply(8'h0B, 16'hFFF0, 16'h9999, 8'hF0);
    check("R3 addi zero-extend", acc_next, 16'h00E0);
    apply(8'h0B, 16'h0100, 16'h0000, 8'h23);
    check("R3 addi", acc_next, 16'h0123);
  endtask

  task automatic test_shifts();
    apply(8'h0D, 16'h8001, 16'h0000, 8'h01);
    check("R4 shl by 1", acc_next, 16'h0002);
    apply(8'h0D, 16'h0001, 16'h0000, 8'h0F);
    check("R4 shl by 15", acc_next, 16'h8000);
    apply(8'h0D, 16'h1234, 16'h0000, 8'h00);
    check("R4 shl by 0", acc_next, 16'h1234);
    apply(8'h0E, 16'h8000, 16'h0000, 8'h0F);
    check("R5 shr logical 15", acc_next, 16'h0001);
    apply(8'h0E, 16'hF000, 16'h0000, 8'h04);
    check("R5 shr by 4", acc_next, 16'h0F00);
  endtask

  task automatic test_shift_upper_ignored();
    apply(8'h0D, 16'h0001, 16'h0000, 8'h31);
    check("R6 shl upper nibble", acc_next, 16'h0002);
    apply(8'h0E, 16'h8000, 16'h0000, 8'hF2);
    check("R6 shr upper nibble", acc_next, 16'h2000);
    apply(8'h0D, 16'h00FF, 16'h0000, 8'h80);
    check("R6 shl amount zero", acc_next, 16'h00FF);
  endtask

  task automatic test_load();
    apply(8'h02, 16'h5555, 16'h1234, 8'h77);
    check("R7 load", acc_next, 16'h1234);
  endtask

  task automatic test_we_and_hold();
    for (int i = 0; i < 256; i++) begin
      logic exp_we;
      exp_we = (i == 8'h00) || (i == 8'h02) || (i == 8'h05) || (i == 8'h06) ||
               (i == 8'h07) || (i == 8'h08) || (i == 8'h0B) || (i == 8'h0D) ||
               (i == 8'h0E);
      apply(8'(i), 16'h5A3C, 16'h0F0F, 8'h03);
      check($sformatf("R8 we op %02h", i), {15'd0, acc_we}, {15'd0, exp_we});
      if (!exp_we) check($sformatf("R9 hold op %02h", i), acc_next, 16'h5A3C);
    end
  endtask

  task automatic test_flags();
    apply(8'h01, 16'h0000, 16'hFFFF, 8'h00);
    check("R10 zero on 0", {15'd0, zero}, 16'd1);
    check("R11 neg on 0", {15'd0, neg}, 16'd0);
    apply(8'h01, 16'h8000, 16'h0000, 8'h00);
    check("R11 neg on 8000", {15'd0, neg}, 16'd1);
    check("R10 zero on 8000", {15'd0, zero}, 16'd0);
    apply(8'h04, 16'h0001, 16'h0000, 8'h00);
    check("R10 zero on 1", {15'd0, zero}, 16'd0);
    check("R11 neg on 1", {15'd0, neg}, 16'd0);
    apply(8'h04, 16'h7FFF, 16'h0000, 8'h00);
    check("R11 neg on 7FFF", {15'd0, neg}, 16'd0);
  endtask

  initial begin
    opcode = 8'h00; acc = 16'h0000; mdr = 16'h0000; field = 8'h00;
    test_idle_state();
    test_add_sub();
    test_bitwise();
    test_addi();
    test_shifts();
    test_shift_upper_ignored();
    test_load();
    test_we_and_hold();
    test_flags();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule